// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading translation descriptors from memory. A walk starts from a table base held in a translation base input. It reads one first-level descriptor, chosen by the top twelve address bits. That descriptor either maps a 1 MB section at once or points to a second-level table. A second-level descriptor, chosen by the next eight address bits, then maps a 64 KB large page or a 4 KB small page. The untranslated low bits of the address are joined to the frame base to form the result.

Descriptors are fetched over a read port with variable delay. The walker holds `mem_rd` and a stable `mem_addr` until the memory answers with a one-cycle `mem_done` that carries `mem_rdata`. Only one walk runs at a time. The walker ends with either a one-cycle result pulse or a one-cycle fault pulse that carries the offending virtual address.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_rd`, `resp_valid` and `page_fault` are 0.
- R2: The cycle after a request is accepted, the walker reads the first-level descriptor at address {base[31:14], va[31:20], 2'b00}, where base is the `ttb_base` value sampled with the request. Bits [13:0] of `ttb_base` are ignored.
- R3: A first-level descriptor whose bits [1:0] are 2'b10 maps a section. The physical address is {desc[31:20], va[19:0]} and no second read is made.
- R4: A first-level descriptor whose bits [1:0] are 2'b01 points to a second-level table. The next read is at {desc[31:10], va[19:12], 2'b00}.
- R5: A second-level descriptor whose bits [1:0] are 2'b01 maps a large page, giving {desc[31:16], va[15:0]}.
- R6: A second-level descriptor whose bits [1:0] are 2'b10 maps a small page, giving {desc[31:12], va[11:0]}.
- R7: A descriptor whose bits [1:0] are 2'b00 or 2'b11, at either level, ends the walk. `page_fault` is then high for exactly one cycle with `fault_vaddr` equal to the walked address, and `resp_valid` stays low.
- R8: Between acceptance and the end of the walk, `req_ready` is 0 and any `req_valid` is ignored. `mem_rd` is 0 whenever the walker is idle.
- R9: `resp_valid` is high for exactly one cycle, in the cycle after the edge on which the final descriptor's `mem_done` was sampled. `resp_paddr` is valid with it.
- R10: While `mem_rd` is high and `mem_done` is low, `mem_rd` stays high and `mem_addr` stays unchanged into the next cycle, however many cycles the memory waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk for `req_vaddr` |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle; a request is accepted now |
| ttb_base | input | 32 | Translation table base (bits [31:14] used) |
| mem_rd | output | 1 | Descriptor read in progress |
| mem_addr | output | 32 | Descriptor byte address |
| mem_done | input | 1 | Memory has returned data this cycle |
| mem_rdata | input | 32 | Descriptor word, valid with `mem_done` |
| resp_valid | output | 1 | One-cycle pulse: translation complete |
| resp_paddr | output | 32 | Translated physical address |
| page_fault | output | 1 | One-cycle pulse: invalid descriptor met |
| fault_vaddr | output | 32 | Virtual address whose walk faulted |

## Verification
A wrong walk state shows up at the ports within one memory response. A wrong level or type decode picks the wrong splice width or skips or adds a second read, and that gives a wrong `resp_paddr` or a fault in place of a result in the cycle after `mem_done`. A latched address or base that has drifted moves `mem_addr`, so the memory returns a different descriptor and the final address is wrong at the end of the walk. A walker that does not return to idle holds `req_ready` low, and the next request then stalls at once.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_L1   = 2'd1,
    ST_L2   = 2'd2
  } walk_state_t;

  typedef enum logic [1:0] {
    DK_FAULT = 2'b00,
    DK_LINK  = 2'b01,
    DK_MAP   = 2'b10,
    DK_RSVD  = 2'b11
  } desc_kind_t;

  typedef enum logic [1:0] {
    LS_SECTION = 2'd0,
    LS_LARGE   = 2'd1,
    LS_SMALL   = 2'd2
  } leaf_size_t;

endpackage

// File: rtl/pt_desc_decode.sv
module pt_desc_decode
  import pt_walk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] desc,
  input  logic              level2,
  output logic              is_fault,
  output logic              is_link,
  output logic              is_leaf,
  output leaf_size_t        leaf_size
);

  desc_kind_t kind;
  assign kind = desc_kind_t'(desc[1:0]);

  always_comb begin
    is_fault  = (kind == DK_FAULT) || (kind == DK_RSVD);
    is_link   = !level2 && (kind == DK_LINK);
    is_leaf   = (kind == DK_MAP) || (level2 && (kind == DK_LINK));
    if (!level2)
      leaf_size = LS_SECTION;
    else if (kind == DK_LINK)
      leaf_size = LS_LARGE;
    else
      leaf_size = LS_SMALL;
  end

endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen
  import pt_walk_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int L1_BITS     = 12,
  parameter int L2_BITS     = 8,
  parameter int PAGE_SHIFT  = 12,
  parameter int LARGE_SHIFT = 16
) (
  input  logic [ADDR_W-1:0] va,
  input  logic [ADDR_W-1:0] ttb,
  input  logic [ADDR_W-1:0] link,
  input  logic [ADDR_W-1:0] desc,
  input  leaf_size_t        leaf_size,
  output logic [ADDR_W-1:0] l1_addr,
  output logic [ADDR_W-1:0] l2_addr,
  output logic [ADDR_W-1:0] leaf_addr
);

  localparam int SECT_SHIFT = PAGE_SHIFT + L2_BITS;
  localparam int TTB_ALIGN  = L1_BITS + 2;
  localparam int L2_ALIGN   = L2_BITS + 2;

  function automatic logic [ADDR_W-1:0] low_mask(input int unsigned s);
    return ~({ADDR_W{1'b1}} << s);
  endfunction

  function automatic logic [ADDR_W-1:0] splice(input logic [ADDR_W-1:0] hi,
                                               input logic [ADDR_W-1:0] lo,
                                               input int unsigned s);
    return (hi & ~low_mask(s)) | (lo & low_mask(s));
  endfunction

  function automatic logic [ADDR_W-1:0] entry_offset(input logic [ADDR_W-1:0] idx,
                                                     input int unsigned bits);
    return (idx & low_mask(bits)) << 2;
  endfunction

  always_comb begin
    l1_addr = splice(ttb, entry_offset(va >> SECT_SHIFT, L1_BITS), TTB_ALIGN);
    l2_addr = splice(link, entry_offset(va >> PAGE_SHIFT, L2_BITS), L2_ALIGN);
    case (leaf_size)
      LS_SECTION: leaf_addr = splice(desc, va, SECT_SHIFT);
      LS_LARGE:   leaf_addr = splice(desc, va, LARGE_SHIFT);
      default:    leaf_addr = splice(desc, va, PAGE_SHIFT);
    endcase
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int L1_BITS     = 12,
  parameter int L2_BITS     = 8,
  parameter int PAGE_SHIFT  = 12,
  parameter int LARGE_SHIFT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] ttb_base,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_done,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              resp_valid,
  output logic [ADDR_W-1:0] resp_paddr,
  output logic              page_fault,
  output logic [ADDR_W-1:0] fault_vaddr
);

  walk_state_t       state_q;
  logic [ADDR_W-1:0] va_q, ttb_q, link_q;

  logic              is_fault, is_link, is_leaf;
  leaf_size_t        leaf_size;
  logic [ADDR_W-1:0] l1_addr, l2_addr, leaf_addr;

  // Named internal events
  logic accept, step_done, leaf_hit, fault_hit, link_hit;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign mem_rd    = (state_q != ST_IDLE);
  assign mem_addr  = (state_q == ST_L2) ? l2_addr : l1_addr;
  assign step_done = mem_rd && mem_done;
  assign leaf_hit  = step_done && is_leaf;
  assign fault_hit = step_done && is_fault;
  assign link_hit  = step_done && is_link;

  pt_desc_decode #(.ADDR_W(ADDR_W)) u_decode (
    .desc      (mem_rdata),
    .level2    (state_q == ST_L2),
    .is_fault  (is_fault),
    .is_link   (is_link),
    .is_leaf   (is_leaf),
    .leaf_size (leaf_size)
  );

  pt_addr_gen #(
    .ADDR_W      (ADDR_W),
    .L1_BITS     (L1_BITS),
    .L2_BITS     (L2_BITS),
    .PAGE_SHIFT  (PAGE_SHIFT),
    .LARGE_SHIFT (LARGE_SHIFT)
  ) u_addr (
    .va        (va_q),
    .ttb       (ttb_q),
    .link      (link_q),
    .desc      (mem_rdata),
    .leaf_size (leaf_size),
    .l1_addr   (l1_addr),
    .l2_addr   (l2_addr),
    .leaf_addr (leaf_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      va_q        <= '0;
      ttb_q       <= '0;
      link_q      <= '0;
      resp_valid  <= 1'b0;
      resp_paddr  <= '0;
      page_fault  <= 1'b0;
      fault_vaddr <= '0;
    end else begin
      resp_valid <= leaf_hit;
      page_fault <= fault_hit;
      if (leaf_hit)  resp_paddr  <= leaf_addr;
      if (fault_hit) fault_vaddr <= va_q;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            va_q    <= req_vaddr;
            ttb_q   <= ttb_base;
            state_q <= ST_L1;
          end
        end
        ST_L1, ST_L2: begin
          if (link_hit) begin
            link_q  <= mem_rdata;
            state_q <= ST_L2;
          end else if (step_done) begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic [ADDR_W-1:0] ttb_base,
  input logic              mem_rd,
  input logic              mem_done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              resp_valid,
  input logic              page_fault,
  input logic [ADDR_W-1:0] fault_vaddr,
  input logic [ADDR_W-1:0] walk_va
);

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd);  // R8

  AST_ACCEPT_STARTS_L1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && mem_rd &&
      mem_addr == {$past(ttb_base[31:14]), $past(req_vaddr[31:20]), 2'b00}));  // R2

  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_done) |=> (mem_rd && $stable(mem_addr)));  // R10

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);  // R9

  AST_RESP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(mem_done));  // R9

  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    page_fault |=> !page_fault);  // R7

  AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(page_fault && resp_valid));  // R7

  AST_FAULT_VADDR: assert property (@(posedge clk) disable iff (!rst_n)
    page_fault |-> (fault_vaddr == $past(walk_va)));  // R7

endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_vaddr   (req_vaddr),
  .ttb_base    (ttb_base),
  .mem_rd      (mem_rd),
  .mem_done    (mem_done),
  .mem_addr    (mem_addr),
  .resp_valid  (resp_valid),
  .page_fault  (page_fault),
  .fault_vaddr (fault_vaddr),
  .walk_va     (va_q)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;

  localparam logic [31:0] TTB = 32'h0001_C000;
  localparam logic [31:0] L2B = 32'h0080_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready;
  logic [31:0] ttb_base = TTB;
  logic        mem_rd;
  logic [31:0] mem_addr;
  logic        mem_done = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        resp_valid;
  logic [31:0] resp_paddr;
  logic        page_fault;
  logic [31:0] fault_vaddr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int wait_cnt = 0;
  int lat = 0;

  always #2.5 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_ready(req_ready), .ttb_base(ttb_base), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_done(mem_done), .mem_rdata(mem_rdata),
    .resp_valid(resp_valid), .resp_paddr(resp_paddr),
    .page_fault(page_fault), .fault_vaddr(fault_vaddr)
  );

  function automatic logic [31:0] hsh(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  // Table contents: type chosen by index mod 4, junk in ignored bits
  function automatic logic [31:0] model(input logic [31:0] a);
    logic [31:0] h = hsh(a);
    logic [31:0] i, j;
    if (a < L2B) begin
      i = (a - TTB) >> 2;
      case (i % 4)
        0: return {h[31:2], 2'b00};
        1: return (L2B + (i << 10)) | (h & 32'h0000_03FC) | 32'd1;
        2: return {h[31:2], 2'b10};
        default: return {h[31:2], 2'b11};
      endcase
    end else begin
      j = ((a - L2B) >> 2) & 32'hFF;
      case (j % 4)
        0: return {h[31:2], 2'b00};
        1: return {h[31:2], 2'b01};
        2: return {h[31:2], 2'b10};
        default: return {h[31:2], 2'b11};
      endcase
    end
  endfunction

  // Variable-delay memory responder
  always @(negedge clk) begin
    if (mem_done) begin
      mem_done <= 1'b0;
    end else if (mem_rd) begin
      if (wait_cnt >= lat) begin
        mem_done  <= 1'b1;
        mem_rdata <= model(mem_addr);
        wait_cnt  <= 0;
        lat       <= (lat + 1) % 4;
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected outcome computed from the requirements
  task automatic expect_walk(input logic [31:0] va, output logic fault,
                             output logic [31:0] pa, output string tag);
    logic [31:0] i = {20'd0, va[31:20]};
    logic [31:0] j = {24'd0, va[19:12]};
    logic [31:0] h1 = hsh(TTB + (i << 2));
    logic [31:0] h2 = hsh(L2B + (i << 10) + (j << 2));
    fault = 1'b0;
    pa = '0;
    case (i % 4)
      2: begin pa = {h1[31:20], va[19:0]}; tag = "R3 section"; end
      1: begin
        case (j % 4)
          1: begin pa = {h2[31:16], va[15:0]}; tag = "R5 R4 large"; end
          2: begin pa = {h2[31:12], va[11:0]}; tag = "R6 R4 small"; end
          default: begin fault = 1'b1; tag = "R7 R4 level2 fault"; end
        endcase
      end
      default: begin fault = 1'b1; tag = "R7 level1 fault"; end
    endcase
  endtask

  task automatic do_walk(input logic [31:0] va, input logic inject,
                         input logic [31:0] ttb_in);
    logic        efault;
    logic [31:0] epa;
    string       tag;
    int          n = 0;
    expect_walk(va, efault, epa, tag);
    ttb_base  = ttb_in;
    req_valid = 1'b1;
    req_vaddr = va;
    check(req_ready, "R8 ready before request", {31'd0, req_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    ttb_base  = 32'hFFFF_FFFF;
    check(!req_ready, "R8 busy after accept", {31'd0, req_ready}, 32'd0);
    if (inject) begin
      req_valid = 1'b1;
      req_vaddr = ~va;
      @(negedge clk);
      req_valid = 1'b0;
      n++;
    end
    while (!resp_valid && !page_fault && n < 40) begin
      @(negedge clk);
      n++;
    end
    if (efault) begin
      check(page_fault && !resp_valid, tag, {31'd0, page_fault}, 32'd1);
      check(fault_vaddr == va, "R7 fault address", fault_vaddr, va);
    end else begin
      check(resp_valid && !page_fault, tag, {31'd0, resp_valid}, 32'd1);
      check(resp_paddr == epa, tag, resp_paddr, epa);
    end
    @(negedge clk);
    check(!resp_valid && !page_fault, "R9 R7 single-cycle pulse",
          {30'd0, resp_valid, page_fault}, 32'd0);
    check(!mem_rd && req_ready, "R8 idle after walk", {30'd0, mem_rd, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready && !mem_rd && !resp_valid && !page_fault, "R1 reset state",
          {28'd0, req_ready, mem_rd, resp_valid, page_fault}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mem_rd, "R1 no read while idle", {31'd0, mem_rd}, 32'd0);
    for (int i = 0; i < 64; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [31:0] jj  = (j * 37 + i) & 32'hFF;
        logic [31:0] off = (i * j * 32'h1357 + j) & 32'hFFF;
        logic [31:0] va  = (i << 20) | (jj << 12) | off;
        logic [31:0] tb  = ((i + j) % 3 == 0) ? (TTB | 32'h0000_2A5C) : TTB;
        // R2: junk low base bits must not change the result
        do_walk(va, ((i + j) % 5) == 0, tb);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule